// File: doc/BRIEF.md
# Pipelined SPI ADC Scan Sequencer

This block is an SPI master that drives a multi-channel successive-approximation ADC. The converter returns each result two frames after the frame whose command picked its channel. The block hides that lag. A start strobe comes in with a 16-bit channel-enable mask. The block then sends one 16-bit command per enabled channel, lowest index first. Two trailing frames follow, whose only job is to clock out the last two results. The block discards the first two words it receives. Each result after that is presented with the channel it was requested for, a one-cycle valid strobe and a per-result tag-error bit. A done pulse marks the end of the operation.

A second mode reads one channel using three frames. The command goes out in the first two frames, and the third frame carries back the result. Every returned word carries the source channel in its top nibble. The block compares this nibble with the channel it expects. On a mismatch it flags the result and sets a sticky error flag. The flag stays set until the next operation starts.

Top module: `adc_scan_seq`

## Requirements
- R1: Each command frame is 16 bits, sent MSB first. The layout is: bit 12 = 1 (manual channel select), bit 11 = 1 (program enable), bits 10:7 = channel number, bit 6 = DOUBLE_RANGE (default 1). All other bits are 0.
- R2: A scan of K enabled channels sends exactly K+2 frames. The K command frames visit the enabled channels in ascending index order. MOSI is 0 for the whole of the two trailing frames.
- R3: The word received in frame N belongs to the command of frame N-2, so the first two received words of an operation are dropped. Each later word gives one res_valid_o pulse. With that pulse, res_ch_o carries the expected channel and res_data_o carries received bits 11:(12-RES_BITS). Results appear in ascending channel order.
- R4: If received bits 15:12 differ from the expected channel, res_err_o is 1 with that result and tag_err_o is set. tag_err_o then holds until a new scan or single read is accepted, and it clears at that acceptance.
- R5: When single_i is high with the start strobe, the block reads channel single_ch_i in three frames: the command, the same command again, then an all-zero frame. It produces one result.
- R6: A start with single_i low and an all-zero mask sends no frame. done_o pulses in the next cycle, busy_o stays 0 and tag_err_o is unchanged.
- R7: Chip select (cs_n_o) is high while the block is idle and between frames. SCLK idles high. Data changes on falling SCLK edges and is sampled on rising ones. Each SCLK phase lasts HALF_DIV clock cycles. MOSI is 0 whenever chip select is high.
- R8: A start strobe that arrives while busy_o is high is ignored.
- R9: Out of reset, cs_n_o and sclk_o are 1 and mosi_o, busy_o, done_o, res_valid_o and tag_err_o are 0. done_o is a one-cycle pulse raised while busy_o is already 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe |
| single_i | input | 1 | Select single-channel read for this start |
| single_ch_i | input | CH_W | Channel for a single read |
| ch_mask_i | input | N_CH | Channel-enable mask for a scan |
| sclk_o | output | 1 | SPI clock |
| cs_n_o | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data to the converter |
| miso_i | input | 1 | SPI data from the converter |
| res_valid_o | output | 1 | Result strobe |
| res_ch_o | output | CH_W | Channel of the result |
| res_data_o | output | RES_BITS | Conversion value |
| res_err_o | output | 1 | Tag mismatch on this result |
| tag_err_o | output | 1 | Sticky tag-mismatch flag |
| done_o | output | 1 | End-of-operation pulse |
| busy_o | output | 1 | Operation in progress |

## Verification
The assertions check the following on every cycle:
- chip select stays high and SCLK and MOSI stay quiet while idle and in the inter-frame gaps;
- done_o is a single-cycle pulse and falls outside busy time;
- an empty-mask start answers in one cycle;
- the error flag stays set from mismatch to the next accepted start.

The following need the bench's scenarios and its converter model, which answers two frames late:
- the command encoding and the ascending visit order;
- the zero trailing frames and the repeated command of a single read;
- dropping the first two received words, and pairing each data word with its channel;
- ignoring a start while busy.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int FRAME_W  = 16;
  localparam int TAG_LSB  = 12;

  typedef enum logic [1:0] {FE_IDLE, FE_LOW, FE_HIGH, FE_GAP} fe_state_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_SEND, SQ_WAIT}        sq_state_t;

  // one frame in flight: does it expect a result, and for which channel
  typedef struct packed {
    logic       vld;
    logic [3:0] ch;
  } slot_t;

  function automatic logic [FRAME_W-1:0] make_cmd(input logic [3:0] ch,
                                                  input logic       dbl);
    logic [FRAME_W-1:0] w;
    w       = '0;
    w[12]   = 1'b1;   // manual channel select
    w[11]   = 1'b1;   // program enable
    w[10:7] = ch;
    w[6]    = dbl;    // doubled input range
    return w;
  endfunction

endpackage

// File: rtl/adc_frame_engine.sv
module adc_frame_engine
  import adc_scan_pkg::*;
#(
  parameter int W        = 16,
  parameter int HALF_DIV = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] tx_i,
  input  logic         miso_i,
  output logic         sclk_o,
  output logic         cs_n_o,
  output logic         mosi_o,
  output logic         done_o,
  output logic [W-1:0] rx_o
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(W - 1);

  fe_state_t        st_q, st_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [W-1:0]     tx_q, tx_d;
  logic [W-1:0]     rx_q, rx_d;
  logic             done_q, done_d;
  logic             div_end;

  assign div_end = (div_q == DIV_LAST);

  always_comb begin
    st_d   = st_q;
    div_d  = div_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    case (st_q)
      FE_IDLE: begin
        if (go_i) begin
          st_d  = FE_LOW;
          div_d = '0;
          bit_d = '0;
          tx_d  = tx_i;
        end
      end
      FE_LOW: begin
        if (div_end) begin
          div_d = '0;
          rx_d  = {rx_q[W-2:0], miso_i};   // rising edge: sample
          st_d  = FE_HIGH;
        end else begin
          div_d = div_q + 1'b1;
        end
      end
      FE_HIGH: begin
        if (div_end) begin
          div_d = '0;
          if (bit_q == BIT_LAST) begin
            st_d = FE_GAP;
          end else begin
            bit_d = bit_q + 1'b1;
            tx_d  = {tx_q[W-2:0], 1'b0};   // falling edge: launch next
            st_d  = FE_LOW;
          end
        end else begin
          div_d = div_q + 1'b1;
        end
      end
      FE_GAP: begin
        if (div_end) begin
          div_d  = '0;
          st_d   = FE_IDLE;
          done_d = 1'b1;
        end else begin
          div_d = div_q + 1'b1;
        end
      end
      default: st_d = FE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FE_IDLE;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  assign sclk_o = (st_q != FE_LOW);
  assign cs_n_o = (st_q == FE_IDLE) || (st_q == FE_GAP);
  assign mosi_o = ((st_q == FE_LOW) || (st_q == FE_HIGH)) && tx_q[W-1];
  assign done_o = done_q;
  assign rx_o   = rx_q;

endmodule

// File: rtl/adc_first_set.sv
module adc_first_set #(
  parameter int N = 16
) (
  input  logic [N-1:0]         mask_i,
  output logic [$clog2(N)-1:0] idx_o,
  output logic                 any_o
);

  localparam int IDX_W = $clog2(N);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |mask_i;

endmodule

// File: rtl/adc_result_track.sv
module adc_result_track
  import adc_scan_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               push_i,
  input  slot_t              slot_i,
  input  logic               frame_done_i,
  input  logic [FRAME_W-1:0] rx_i,
  output logic               res_valid_o,
  output logic [3:0]         res_ch_o,
  output logic [RES_BITS-1:0] res_data_o,
  output logic               res_err_o,
  output logic               tag_err_o
);

  slot_t               cur_q, cur_d, d1_q, d1_d, d2_q, d2_d;
  logic                vld_q, vld_d;
  logic [3:0]          ch_q, ch_d;
  logic [RES_BITS-1:0] data_q, data_d;
  logic                err_q, err_d;
  logic                flag_q, flag_d;
  logic                mism;

  assign mism = (rx_i[FRAME_W-1:TAG_LSB] != d2_q.ch);

  always_comb begin
    cur_d  = cur_q;
    d1_d   = d1_q;
    d2_d   = d2_q;
    vld_d  = 1'b0;
    ch_d   = ch_q;
    data_d = data_q;
    err_d  = err_q;
    flag_d = flag_q;
    if (clear_i) begin
      cur_d  = '0;
      d1_d   = '0;
      d2_d   = '0;
      flag_d = 1'b0;
    end else begin
      if (push_i) cur_d = slot_i;
      if (frame_done_i) begin
        d2_d  = d1_q;
        d1_d  = cur_q;
        vld_d = d2_q.vld;
        if (d2_q.vld) begin
          ch_d   = d2_q.ch;
          data_d = rx_i[TAG_LSB-1 -: RES_BITS];
          err_d  = mism;
          if (mism) flag_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      d1_q   <= '0;
      d2_q   <= '0;
      vld_q  <= 1'b0;
      ch_q   <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      d1_q   <= d1_d;
      d2_q   <= d2_d;
      vld_q  <= vld_d;
      ch_q   <= ch_d;
      data_q <= data_d;
      err_q  <= err_d;
      flag_q <= flag_d;
    end
  end

  assign res_valid_o = vld_q;
  assign res_ch_o    = ch_q;
  assign res_data_o  = data_q;
  assign res_err_o   = err_q;
  assign tag_err_o   = flag_q;

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int   N_CH         = 16,
  parameter int   RES_BITS     = 12,
  parameter int   HALF_DIV     = 2,
  parameter logic DOUBLE_RANGE = 1'b1,
  localparam int  CH_W         = $clog2(N_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                single_i,
  input  logic [CH_W-1:0]     single_ch_i,
  input  logic [N_CH-1:0]     ch_mask_i,
  output logic                sclk_o,
  output logic                cs_n_o,
  output logic                mosi_o,
  input  logic                miso_i,
  output logic                res_valid_o,
  output logic [CH_W-1:0]     res_ch_o,
  output logic [RES_BITS-1:0] res_data_o,
  output logic                res_err_o,
  output logic                tag_err_o,
  output logic                done_o,
  output logic                busy_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic rs1_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q   <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rs1_q   <= 1'b1;
      rst_s_n <= rs1_q;
    end
  end

  sq_state_t          sq_q, sq_d;
  logic [N_CH-1:0]    rem_q, rem_d;
  logic [1:0]         fill_q, fill_d;
  logic               single_q, single_d;
  logic [CH_W-1:0]    last_q, last_d;
  logic               done_q, done_d;
  logic               go, push, clear;
  logic [FRAME_W-1:0] tx_word;
  slot_t              slot;
  logic [CH_W-1:0]    pick_idx;
  logic               pick_any;
  logic               fe_done;
  logic [FRAME_W-1:0] fe_rx;
  logic [3:0]         trk_ch;

  adc_first_set #(.N(N_CH)) u_pick (
    .mask_i (rem_q),
    .idx_o  (pick_idx),
    .any_o  (pick_any)
  );

  always_comb begin
    sq_d     = sq_q;
    rem_d    = rem_q;
    fill_d   = fill_q;
    single_d = single_q;
    last_d   = last_q;
    done_d   = 1'b0;
    go       = 1'b0;
    push     = 1'b0;
    clear    = 1'b0;
    tx_word  = '0;
    slot     = '0;
    case (sq_q)
      SQ_IDLE: begin
        if (start_i) begin
          if (single_i) begin
            rem_d    = N_CH'(1) << single_ch_i;
            single_d = 1'b1;
            fill_d   = '0;
            clear    = 1'b1;
            sq_d     = SQ_SEND;
          end else if (|ch_mask_i) begin
            rem_d    = ch_mask_i;
            single_d = 1'b0;
            fill_d   = '0;
            clear    = 1'b1;
            sq_d     = SQ_SEND;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      SQ_SEND: begin
        go   = 1'b1;
        push = 1'b1;
        if (pick_any) begin
          tx_word  = make_cmd(4'(pick_idx), DOUBLE_RANGE);
          slot.vld = 1'b1;
          slot.ch  = 4'(pick_idx);
          rem_d    = rem_q & ~(N_CH'(1) << pick_idx);
          last_d   = pick_idx;
        end else begin
          if (single_q && (fill_q == 2'd0))
            tx_word = make_cmd(4'(last_q), DOUBLE_RANGE);
          fill_d = fill_q + 1'b1;
        end
        sq_d = SQ_WAIT;
      end
      SQ_WAIT: begin
        if (fe_done) begin
          if (!(|rem_q) && (fill_q == 2'd2)) begin
            sq_d   = SQ_IDLE;
            done_d = 1'b1;
          end else begin
            sq_d = SQ_SEND;
          end
        end
      end
      default: sq_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      sq_q     <= SQ_IDLE;
      rem_q    <= '0;
      fill_q   <= '0;
      single_q <= 1'b0;
      last_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      sq_q     <= sq_d;
      rem_q    <= rem_d;
      fill_q   <= fill_d;
      single_q <= single_d;
      last_q   <= last_d;
      done_q   <= done_d;
    end
  end

  adc_frame_engine #(.W(FRAME_W), .HALF_DIV(HALF_DIV)) u_fe (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .go_i   (go),
    .tx_i   (tx_word),
    .miso_i (miso_i),
    .sclk_o (sclk_o),
    .cs_n_o (cs_n_o),
    .mosi_o (mosi_o),
    .done_o (fe_done),
    .rx_o   (fe_rx)
  );

  adc_result_track #(.RES_BITS(RES_BITS)) u_trk (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .clear_i      (clear),
    .push_i       (push),
    .slot_i       (slot),
    .frame_done_i (fe_done),
    .rx_i         (fe_rx),
    .res_valid_o  (res_valid_o),
    .res_ch_o     (trk_ch),
    .res_data_o   (res_data_o),
    .res_err_o    (res_err_o),
    .tag_err_o    (tag_err_o)
  );

  assign res_ch_o = CH_W'(trk_ch);
  assign done_o   = done_q;
  assign busy_o   = (sq_q != SQ_IDLE);

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int N_CH = 16,
  localparam int CH_W = $clog2(N_CH)
) (
  input logic            clk,
  input logic            rst_s_n,
  input logic            start_i,
  input logic            single_i,
  input logic [N_CH-1:0] ch_mask_i,
  input logic            sclk_o,
  input logic            cs_n_o,
  input logic            mosi_o,
  input logic            res_valid_o,
  input logic            res_err_o,
  input logic            tag_err_o,
  input logic            done_o,
  input logic            busy_o
);

  logic accept;
  assign accept = start_i && !busy_o && (single_i || (|ch_mask_i));

  p_cs_idle_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    !busy_o |-> cs_n_o);

  p_sclk_idle_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    cs_n_o |-> sclk_o);

  p_mosi_quiet_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    cs_n_o |-> !mosi_o);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |=> !done_o);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |-> !busy_o);

  p_empty_done_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (start_i && !busy_o && !single_i && !(|ch_mask_i)) |=> (done_o && !busy_o));

  p_err_flag_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (res_valid_o && res_err_o) |-> tag_err_o);

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (tag_err_o && !accept) |=> tag_err_o);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.N_CH(N_CH)) u_chk (
  .clk         (clk),
  .rst_s_n     (rst_s_n),
  .start_i     (start_i),
  .single_i    (single_i),
  .ch_mask_i   (ch_mask_i),
  .sclk_o      (sclk_o),
  .cs_n_o      (cs_n_o),
  .mosi_o      (mosi_o),
  .res_valid_o (res_valid_o),
  .res_err_o   (res_err_o),
  .tag_err_o   (tag_err_o),
  .done_o      (done_o),
  .busy_o      (busy_o)
);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        single_i = 1'b0;
  logic [3:0]  single_ch_i = '0;
  logic [15:0] ch_mask_i = '0;
  logic        sclk_o, cs_n_o, mosi_o;
  logic        miso_i = 1'b0;
  logic        res_valid_o, res_err_o, tag_err_o, done_o, busy_o;
  logic [3:0]  res_ch_o;
  logic [11:0] res_data_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  int bad_ch = -1;

  typedef struct {int ch; int data; bit err;} exp_t;
  exp_t exp_res[$];
  int   exp_tx[$];
  int   got_tx[$];

  always #10 clk = ~clk;

  adc_scan_seq #(.N_CH(16), .RES_BITS(12), .HALF_DIV(2), .DOUBLE_RANGE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .single_i(single_i),
    .single_ch_i(single_ch_i), .ch_mask_i(ch_mask_i), .sclk_o(sclk_o),
    .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .res_valid_o(res_valid_o), .res_ch_o(res_ch_o), .res_data_o(res_data_o),
    .res_err_o(res_err_o), .tag_err_o(tag_err_o), .done_o(done_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int cmd_of(input int ch);
    return (1 << 12) | (1 << 11) | (ch << 7) | (1 << 6);
  endfunction

  function automatic int data_of(input int ch);
    return (ch * 273 + 5) & 12'hFFF;
  endfunction

  // converter model: answers with the channel commanded two frames earlier
  int  hist1 = 0, hist2 = 0, bitcnt = 0, rxw = 0, resp = 0;
  bit  p_cs = 1'b1, p_sclk = 1'b1;
  always @(negedge clk) begin
    if (p_cs && !cs_n_o) begin
      int ch;
      ch = (hist2 >> 7) & 15;
      if ((hist2 >> 11) & 1)
        resp = (((ch == bad_ch) ? (ch ^ 1) : ch) << 12) | data_of(ch);
      else
        resp = 16'hFFFF;
      bitcnt = 0;
      rxw    = 0;
      miso_i = resp[15];
    end else if (!cs_n_o) begin
      if (!p_sclk && sclk_o) begin
        rxw = ((rxw << 1) | int'(mosi_o)) & 16'hFFFF;
        bitcnt++;
        if (bitcnt == 16) begin
          got_tx.push_back(rxw);
          hist2 = hist1;
          hist1 = rxw;
        end
      end else if (p_sclk && !sclk_o) begin
        miso_i = resp[15 - bitcnt];
      end
    end
    p_cs   = cs_n_o;
    p_sclk = sclk_o;
  end

  // per-clock comparison against the expected result stream
  always @(negedge clk) begin
    if (rst_n && cyc > 4) begin
      if (!busy_o) chk(cs_n_o == 1'b1, "R7", "cs_n while idle", cs_n_o, 1);
      if (cs_n_o)  chk(mosi_o == 1'b0, "R7", "mosi with cs high", mosi_o, 0);
      if (res_valid_o) begin
        if (exp_res.size() == 0) begin
          chk(1'b0, "R3", "unexpected result ch", res_ch_o, 0);
        end else begin
          exp_t e;
          e = exp_res.pop_front();
          chk(res_ch_o == e.ch, "R3", "result channel", res_ch_o, e.ch);
          chk(res_data_o == e.data, "R3", "result data", res_data_o, e.data);
          chk(res_err_o == e.err, "R4", "result tag error", res_err_o, e.err);
        end
      end
    end
  end

  task automatic summary_and_end();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      summary_and_end();
    end
  end

  // run one operation; poke issues a second start while busy (R8)
  task automatic do_op(input logic [15:0] mask, input bit sgl, input int sch,
                       input bit poke, input string req);
    int k;
    exp_tx.delete();
    got_tx.delete();
    if (sgl) begin
      exp_tx.push_back(cmd_of(sch));
      exp_tx.push_back(cmd_of(sch));
      exp_tx.push_back(0);
      exp_res.push_back('{sch, data_of(sch), sch == bad_ch});
    end else if (mask != 0) begin
      for (int c = 0; c < 16; c++) begin
        if (mask[c]) begin
          exp_tx.push_back(cmd_of(c));
          exp_res.push_back('{c, data_of(c), c == bad_ch});
        end
      end
      exp_tx.push_back(0);
      exp_tx.push_back(0);
    end
    @(negedge clk);
    ch_mask_i   = mask;
    single_i    = sgl;
    single_ch_i = 4'(sch);
    start_i     = 1'b1;
    k = 0;
    while (k < 4000) begin
      @(negedge clk);
      k++;
      if (k == 1) start_i = 1'b0;
      if (poke && k == 40) begin
        ch_mask_i = 16'hFFFF;
        start_i   = 1'b1;
      end
      if (poke && k == 41) start_i = 1'b0;
      if (done_o) break;
    end
    chk(done_o == 1'b1, req, "done seen", done_o, 1);
    if (!sgl && mask == 0) begin
      chk(k == 1, "R6", "empty-mask done latency", k, 1);
      chk(busy_o == 1'b0, "R6", "busy after empty start", busy_o, 0);
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R9", "done width", done_o, 0);
    chk(got_tx.size() == exp_tx.size(), req, "frame count",
        got_tx.size(), exp_tx.size());
    for (int i = 0; i < exp_tx.size() && i < got_tx.size(); i++)
      chk(got_tx[i] == exp_tx[i], req, "frame word", got_tx[i], exp_tx[i]);
    chk(exp_res.size() == 0, "R3", "results left over", exp_res.size(), 0);
    exp_res.delete();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(cs_n_o == 1'b1, "R9", "reset cs_n", cs_n_o, 1);
    chk(sclk_o == 1'b1, "R9", "reset sclk", sclk_o, 1);
    chk(mosi_o == 1'b0, "R9", "reset mosi", mosi_o, 0);
    chk(busy_o == 1'b0, "R9", "reset busy", busy_o, 0);
    chk(res_valid_o == 1'b0, "R9", "reset valid", res_valid_o, 0);
    chk(tag_err_o == 1'b0, "R9", "reset tag_err", tag_err_o, 0);

    do_op(16'h0001, 1'b0, 0, 1'b0, "R1");   // single channel scan, K+2 = 3
    do_op(16'h8421, 1'b0, 0, 1'b0, "R2");   // sparse mask, ascending order
    do_op(16'hFFFF, 1'b0, 0, 1'b0, "R2");   // all channels
    do_op(16'h0000, 1'b0, 0, 1'b0, "R6");   // empty mask
    do_op(16'h0000, 1'b1, 7, 1'b0, "R5");   // single read of channel 7
    do_op(16'h0003, 1'b0, 0, 1'b1, "R8");   // second start while busy ignored

    bad_ch = 5;                              // tag mismatch on channel 5
    do_op(16'h0060, 1'b0, 0, 1'b0, "R4");
    chk(tag_err_o == 1'b1, "R4", "flag set after mismatch", tag_err_o, 1);
    bad_ch = -1;
    do_op(16'h0000, 1'b0, 0, 1'b0, "R6");
    chk(tag_err_o == 1'b1, "R6", "flag kept over empty start", tag_err_o, 1);
    do_op(16'h0101, 1'b0, 0, 1'b0, "R4");
    chk(tag_err_o == 1'b0, "R4", "flag cleared by new scan", tag_err_o, 0);

    summary_and_end();
  end

endmodule